// File: doc/BRIEF.md
# ADC Sample-Hold Sequencing Controller

This block runs a single-channel sampling converter in continuous mode. A start request can come from any of three sources: a PWM event line, a software strobe or an external start pin. Once started, the controller produces a repeating sample/hold pulse. The pulse is timed in converter clocks, where one converter clock equals two system clocks. The input is captured when the pulse falls. The block then tracks the conversion latency, loads each converted value into a result register, and raises an interrupt flag shortly after each load.

A 4-bit acquisition field sets the pulse width. A mode input selects continuous single-channel operation when low. When the mode input is high, the sequence halts and new starts are refused. The analog converter is replaced by a stub that returns the value present on a digital input at the moment of capture. Conversions that are already in flight finish even after a halt.

Top module: `adc_sh_seq`

## Requirements
- R1: During and after a synchronous reset, `sh_pulse`, `irq_flag` and `result` are all 0.
- R2: When idle with `mode_sel` = 0, a high level on any of `trig_pwm`, `trig_sw` or `trig_ext` at a clock edge starts a continuous sequence.
- R3: The first rise of `sh_pulse` follows the edge that sampled the start 5 system clocks later, which is 2.5 converter clocks.
- R4: Each `sh_pulse` is high for 2*(1+A) system clocks. A is the value of `acq_width` latched at the start edge; changes to `acq_width` during a sequence have no effect.
- R5: While the sequence runs, successive rises of `sh_pulse` are 2*(2+A) system clocks apart.
- R6: The converted value is the `adc_din` value sampled at the edge where `sh_pulse` falls.
- R7: `result` takes each converted value 8 system clocks (4 converter clocks) after its falling edge and holds it otherwise.
- R8: `irq_flag` sets 2 system clocks after each `result` load. It stays set until an `irq_clr` pulse clears it. If a set and a clear land on the same edge, the set wins.
- R9: A start request that arrives while a sequence runs is ignored and does not shift the pulse timing.
- R10: With `mode_sel` = 1, start requests are ignored. A running sequence stops at that edge, with `sh_pulse` low afterwards. A pulse cut short this way is not converted, but conversions already captured still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pwm | input | 1 | Start request from PWM event |
| trig_sw | input | 1 | Start request from software |
| trig_ext | input | 1 | Start request from external pin |
| acq_width | input | 4 | Acquisition field A, pulse width 1+A converter clocks |
| mode_sel | input | 1 | 0: continuous single channel, 1: halt |
| adc_din | input | 12 | Digital value returned by the converter stub |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| sh_pulse | output | 1 | Sample/hold pulse |
| result | output | 12 | Result register |
| irq_flag | output | 1 | Conversion-done interrupt flag |

## Verification
Two pairs of events can fall on the same clock edge.

The first pair is the interrupt set and the software clear. The bench holds `irq_clr` high across several result arrivals, so the flag must show exactly one high cycle per result. The bench also drives random clear pulses while results are arriving.

The second pair is a halt and a falling pulse edge. The bench drives random one-cycle `mode_sel` pulses, so some halts land on the falling edge; that pulse must produce no conversion.

Both cases are judged cycle by cycle against a timing model that predicts rises, falls, result loads and flag changes from the start edge alone.

// File: rtl/adc_sh_pkg.sv
package adc_sh_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_DELAY,
    SEQ_HIGH,
    SEQ_LOW
  } seq_state_e;
endpackage

// File: rtl/adc_sh_timer.sv
module adc_sh_timer
  import adc_sh_pkg::*;
#(
  parameter int ACQ_W    = 4,
  parameter int CLK_DIV  = 2,
  parameter int TRIG_DLY = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [ACQ_W-1:0] acq_i,
  output logic             sh_o,
  output logic             fall_o
);
  localparam int MAX_W = (1 << ACQ_W) * CLK_DIV;
  localparam int CNT_W = $clog2(MAX_W + TRIG_DLY) + 1;

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [ACQ_W-1:0] acq_q;
  logic             sh_q;
  logic [CNT_W-1:0] high_m1;
  logic [CNT_W-1:0] low_m1;
  logic [CNT_W-1:0] dly_m1;

  // Counter reload values, all in system clocks
  assign high_m1 = CNT_W'((int'(acq_q) + 1) * CLK_DIV - 1);
  assign low_m1  = CNT_W'(CLK_DIV - 1);
  assign dly_m1  = CNT_W'(TRIG_DLY - 1);

  // A halt on the falling edge suppresses the capture
  assign fall_o = (state == SEQ_HIGH) && (cnt == '0) && !stop_i;
  assign sh_o   = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      acq_q <= '0;
      sh_q  <= 1'b0;
    end else if (stop_i) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      sh_q  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_i) begin
            state <= SEQ_DELAY;
            cnt   <= dly_m1;
            acq_q <= acq_i;
          end
        end
        SEQ_DELAY: begin
          if (cnt == '0) begin
            state <= SEQ_HIGH;
            sh_q  <= 1'b1;
            cnt   <= high_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_HIGH: begin
          if (cnt == '0) begin
            state <= SEQ_LOW;
            sh_q  <= 1'b0;
            cnt   <= low_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_LOW: begin
          if (cnt == '0) begin
            state <= SEQ_HIGH;
            sh_q  <= 1'b1;
            cnt   <= high_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_conv_pipe.sv
module adc_conv_pipe #(
  parameter int RES_W = 12,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [RES_W-1:0] din_i,
  output logic             load_o,
  output logic [RES_W-1:0] data_o
);
  logic [LAT-1:0]   vld;
  logic [RES_W-1:0] dat [LAT];

  // Only the valid bits are reset; data stages stay plain shift registers
  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= LAT'({vld, cap_i});
  end

  always_ff @(posedge clk) begin
    if (cap_i) dat[0] <= din_i;
    for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
  end

  assign load_o = vld[LAT-1];
  assign data_o = dat[LAT-1];
endmodule

// File: rtl/adc_result_irq.sv
module adc_result_irq #(
  parameter int RES_W   = 12,
  parameter int IRQ_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             clr_i,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);
  logic [RES_W-1:0]   res_q;
  logic [IRQ_DLY-1:0] dly;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      dly   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (load_i) res_q <= data_i;
      dly <= IRQ_DLY'({dly, load_i});
      if (dly[IRQ_DLY-1]) irq_q <= 1'b1;   // set wins over clear
      else if (clr_i)     irq_q <= 1'b0;
    end
  end

  assign result_o = res_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/adc_sh_seq.sv
module adc_sh_seq #(
  parameter int RES_W        = 12,
  parameter int ACQ_W        = 4,
  parameter int CLK_DIV      = 2,
  parameter int CONV_LAT_ADC = 4,
  parameter int IRQ_DLY      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_pwm,
  input  logic             trig_sw,
  input  logic             trig_ext,
  input  logic [ACQ_W-1:0] acq_width,
  input  logic             mode_sel,
  input  logic [RES_W-1:0] adc_din,
  input  logic             irq_clr,
  output logic             sh_pulse,
  output logic [RES_W-1:0] result,
  output logic             irq_flag
);
  localparam int TRIG_DLY = (5 * CLK_DIV) / 2;
  localparam int PIPE_LAT = CONV_LAT_ADC * CLK_DIV;

  logic             start;
  logic             cap;
  logic             res_load;
  logic [RES_W-1:0] res_data;

  assign start = !mode_sel && (trig_pwm || trig_sw || trig_ext);

  adc_sh_timer #(
    .ACQ_W(ACQ_W), .CLK_DIV(CLK_DIV), .TRIG_DLY(TRIG_DLY)
  ) u_timer (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(mode_sel),
    .acq_i(acq_width), .sh_o(sh_pulse), .fall_o(cap)
  );

  adc_conv_pipe #(
    .RES_W(RES_W), .LAT(PIPE_LAT)
  ) u_conv (
    .clk(clk), .rst(rst), .cap_i(cap), .din_i(adc_din),
    .load_o(res_load), .data_o(res_data)
  );

  adc_result_irq #(
    .RES_W(RES_W), .IRQ_DLY(IRQ_DLY)
  ) u_res (
    .clk(clk), .rst(rst), .load_i(res_load), .data_i(res_data),
    .clr_i(irq_clr), .result_o(result), .irq_o(irq_flag)
  );
endmodule

// File: rtl/adc_sh_seq_chk.sv
module adc_sh_seq_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_sel,
  input logic             irq_clr,
  input logic             sh_pulse,
  input logic [RES_W-1:0] result,
  input logic             irq_flag,
  input logic             res_load
);
  // R10
  mode_stop_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sel |=> !sh_pulse);

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_load |=> $stable(result));

  // R8
  irq_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(res_load, 3) |-> irq_flag);

  // R8
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(res_load, 3));

  // R8
  irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind adc_sh_seq adc_sh_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .irq_clr(irq_clr),
  .sh_pulse(sh_pulse), .result(result), .irq_flag(irq_flag),
  .res_load(res_load)
);

// File: tb/adc_sh_seq_tb.sv
module adc_sh_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_pwm = 1'b0, trig_sw = 1'b0, trig_ext = 1'b0;
  logic [3:0]  acq_width = '0;
  logic        mode_sel = 1'b0;
  logic [11:0] adc_din = '0;
  logic        irq_clr = 1'b0;
  logic        sh_pulse;
  logic [11:0] result;
  logic        irq_flag;

  int nchk = 0, nerr = 0;
  int ecyc = 0;
  int kstart = 0;
  int rises[$];
  int falls[$];
  logic cmp_on = 1'b0;
  logic prev_sh = 1'b0;
  logic rnd_din = 1'b1;

  // reference model state
  int m_act = 0, m_ps = 0, m_w = 0, m_p2 = 0, rel = 0;
  int rq_due[$];
  int rq_dat[$];
  int iq_due[$];
  int e_sh = 0, e_res = 0, e_irq = 0;

  adc_sh_seq u_dut (
    .clk(clk), .rst(rst), .trig_pwm(trig_pwm), .trig_sw(trig_sw),
    .trig_ext(trig_ext), .acq_width(acq_width), .mode_sel(mode_sel),
    .adc_din(adc_din), .irq_clr(irq_clr), .sh_pulse(sh_pulse),
    .result(result), .irq_flag(irq_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d (edge %0d)", tag, act, exp, ecyc);
    end
  endtask

  // Timing model, evaluated on the inputs seen at each edge
  always @(posedge clk) begin
    ecyc++;
    if (rst) begin
      m_act = 0; e_sh = 0; e_res = 0; e_irq = 0;
      rq_due.delete(); rq_dat.delete(); iq_due.delete();
    end else begin
      if (m_act != 0) begin
        if (mode_sel) m_act = 0;
        else begin
          rel = ecyc - m_ps;
          if (rel >= m_w && (rel % m_p2) == m_w) begin
            rq_due.push_back(ecyc + 8);
            rq_dat.push_back(int'(adc_din));
          end
        end
      end else if (!mode_sel && (trig_pwm || trig_sw || trig_ext)) begin
        m_act = 1;
        m_ps  = ecyc + 5;
        m_w   = 2 * (1 + int'(acq_width));
        m_p2  = 2 * (2 + int'(acq_width));
      end
      e_sh = (m_act != 0 && ecyc >= m_ps && ((ecyc - m_ps) % m_p2) < m_w) ? 1 : 0;
      if (rq_due.size() > 0 && rq_due[0] == ecyc) begin
        e_res = rq_dat.pop_front();
        void'(rq_due.pop_front());
        iq_due.push_back(ecyc + 2);
      end
      if (iq_due.size() > 0 && iq_due[0] == ecyc) begin
        e_irq = 1;
        void'(iq_due.pop_front());
      end else if (irq_clr) e_irq = 0;
    end
  end

  // Per-cycle comparison and pulse edge log
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 R5 sh_pulse vs model", int'(sh_pulse), e_sh);
      chk("R6 R7 result vs model", int'(result), e_res);
      chk("R8 irq_flag vs model", int'(irq_flag), e_irq);
      if (sh_pulse && !prev_sh) rises.push_back(ecyc);
      if (!sh_pulse && prev_sh) falls.push_back(ecyc);
    end
    prev_sh = sh_pulse;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd_din) adc_din = 12'($urandom);
    end
  endtask

  task automatic start_trig(input int src, input int a);
    @(negedge clk);
    acq_width = 4'(a);
    rises.delete(); falls.delete();
    kstart = ecyc + 1;
    if (src == 0) trig_pwm = 1'b1;
    else if (src == 1) trig_sw = 1'b1;
    else trig_ext = 1'b1;
    @(negedge clk);
    trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk);
    mode_sel = 1'b1;
    @(negedge clk);
    chk("R10 sh low after halt", int'(sh_pulse), 0);
    mode_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog expired, no requirement completed");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int hi_cnt;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sh_pulse after reset", int'(sh_pulse), 0);
    chk("R1 irq_flag after reset", int'(irq_flag), 0);
    chk("R1 result after reset", int'(result), 0);
    cmp_on = 1'b1;

    // PWM start, narrowest pulse
    start_trig(0, 0);
    cycles(40);
    chk("R2 pwm start", int'(rises.size() >= 2), 1);
    chk("R3 first rise delay", rises[0] - kstart, 5);
    chk("R4 width acq0", falls[0] - rises[0], 2);
    chk("R5 period acq0", rises[1] - rises[0], 4);
    halt();
    // start refused while halted
    @(negedge clk);
    mode_sel = 1'b1;
    start_trig(1, 3);
    cycles(20);
    chk("R10 no start while halted", rises.size(), 0);
    mode_sel = 1'b0;
    cycles(5);

    // Software start, acq change and extra request mid-run
    start_trig(1, 5);
    cycles(3);
    acq_width = 4'd15;
    cycles(15);
    trig_ext = 1'b1;
    cycles(1);
    trig_ext = 1'b0;
    cycles(60);
    chk("R3 first rise delay sw", rises[0] - kstart, 5);
    chk("R4 width acq5", falls[0] - rises[0], 12);
    chk("R4 width keeps latched acq", falls[2] - rises[2], 12);
    chk("R9 spacing after late request", rises[3] - rises[2], 14);
    chk("R9 spacing later", rises[4] - rises[3], 14);
    halt();
    cycles(20);

    // External start, widest pulse, constant input value
    rnd_din = 1'b0;
    adc_din = 12'hABC;
    start_trig(2, 15);
    cycles(100);
    chk("R2 ext start", int'(rises.size() >= 3), 1);
    chk("R3 first rise delay ext", rises[0] - kstart, 5);
    chk("R4 width acq15", falls[0] - rises[0], 32);
    chk("R5 period acq15", rises[1] - rises[0], 34);
    halt();
    cycles(20);
    chk("R6 R7 result holds captured value", int'(result), 12'hABC);
    chk("R8 flag set", int'(irq_flag), 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 flag cleared", int'(irq_flag), 0);
    rnd_din = 1'b1;

    // Clear held high while results arrive: set must win
    irq_clr = 1'b1;
    start_trig(1, 0);
    hi_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      cycles(1);
      if (irq_flag) hi_cnt++;
    end
    chk("R8 set wins over clear", int'(hi_cnt > 0), 1);
    irq_clr = 1'b0;
    halt();
    cycles(20);

    // Random traffic, judged by the model each cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      adc_din   = 12'($urandom);
      trig_pwm  = ($urandom_range(0, 15) == 0);
      trig_sw   = ($urandom_range(0, 15) == 0);
      trig_ext  = ($urandom_range(0, 15) == 0);
      mode_sel  = ($urandom_range(0, 39) == 0);
      irq_clr   = ($urandom_range(0, 7) == 0);
      acq_width = 4'($urandom);
    end
    @(negedge clk);
    trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0;
    mode_sel = 1'b0; irq_clr = 1'b0;
    cycles(10);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule